// File: doc/BRIEF.md
# Dual-Limit Programmable Event Timer

This block is a 16-bit up-counter that advances on qualified timer events. It wraps to zero when it reaches a programmable maximum-count value. The limit comes either from one register (single-limit mode) or, by turns, from a primary and a secondary register (dual-limit mode). An event is one of three things, chosen by software:
- a service slot of the internal clock;
- a synchronised rising edge on an external clock pin;
- a terminal-count pulse from a neighbouring timer, which makes this timer a prescaled counter.

The timer is serviced only once every four clocks. An optional external gate, also synchronised, holds counting off while it is low.

The block has two outputs:
- The output pin. In single-limit mode it gives a one-clock Low strobe at each wrap. In dual-limit mode it gives a waveform whose level shows which limit is in control, so the two limits set the duty cycle.
- A one-clock terminal-count pulse. It can drive an interrupt line, which lets the timer act as a watchdog: software must rewrite the count before the limit is reached, or the pulse fires.

The count, both limits and a six-bit control word are loaded through write strobes that share one data bus. The count can be rewritten at any time.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0, the output pin is High, the terminal-count pulse is low and the timer is stopped. The control word is 0, so the run bit is clear.
- R2: The count goes up by exactly one per counted event. On the edge where it would reach the active limit it becomes 0 instead, so it never holds a non-zero limit value. The terminal-count pulse is high for that one clock only, and the count reads 0 while the pulse is high.
- R3: In single-limit mode (control bit 1 = 0), the output is Low for exactly the one clock that the terminal-count pulse is high, and High at all other times.
- R4: In dual-limit mode (control bit 1 = 1), each wrap hands control to the other limit register. The output is High while the primary limit is in control and Low while the secondary limit is in control. With primary 3 and secondary 2 on the internal source, the output is Low for 8 clocks and High for 12 clocks.
- R5: With the internal source (control bits 4:3 = 0), the count advances once per four-clock service slot. A primary limit of 5 therefore gives a terminal-count pulse every 20 clocks.
- R6: With the external source (bits 4:3 = 1), each rising edge of the external clock pin counts once. The count has moved by the sixth rising clock edge after the pin is sampled high. A pin held high adds no further counts.
- R7: With the prescaler source (bits 4:3 = 2), each one-clock pulse on the prescale input counts exactly once. The pulse is held until the next service slot, and no counts occur without a pulse.
- R8: When gating is enabled (bit 5 = 1), no events are counted while the synchronised gate pin is low. Counting resumes once the gate is high.
- R9: A count write loads the written value on the next edge, whether the timer is running or stopped. If an increment is due in the same cycle, the write wins.
- R10: A limit value of 0 means 65536 counts: from 0xFFFE the count goes to 0xFFFF, then wraps to 0 with a terminal-count pulse.
- R11: When the continuous bit (bit 2) is 0, the run bit (bit 0) clears at the end of the sequence: after one wrap in single-limit mode, or after the secondary wrap in dual-limit mode. The count then stays at 0 and no further pulses occur.
- R12: Rewriting the count to 0 more often than once per limit period prevents every terminal-count pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_we | input | 1 | Load the count from wdata |
| pri_we | input | 1 | Load the primary limit from wdata |
| sec_we | input | 1 | Load the secondary limit from wdata |
| ctl_we | input | 1 | Load the control word from wdata[5:0] |
| wdata | input | W | Shared write data |
| ext_clk | input | 1 | Asynchronous external event input |
| ext_gate | input | 1 | Asynchronous external gate input |
| pre_tick | input | 1 | Prescaler pulse from another timer |
| count_q | output | W | Current count |
| tmr_out | output | 1 | Timer output pin |
| tc_irq | output | 1 | Terminal-count pulse, usable as a watchdog interrupt |

## Verification
The assertions check four things on every cycle:
- the count never reaches a non-zero active limit;
- the count moves by itself only in a service slot;
- a write is loaded exactly;
- the output moves only together with a terminal-count pulse, in both modes.

Only the bench's scenarios can show the rest: the 20-clock period, the 8/12 duty split, the six-clock external latency, the effect of the gate and the prescaler, the full-range limit of zero, stopping at the end of the sequence, and a watchdog that is kept from firing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // event source selector, control bits 4:3
   typedef enum logic [1:0] {
      SRC_CLK = 2'd0,
      SRC_EXT = 2'd1,
      SRC_PRE = 2'd2
   } src_e;

   // control word; packed MSB first: gate_en=5, src=4:3, cont=2, dual=1, run=0
   typedef struct packed {
      logic gate_en;
      src_e src;
      logic cont;
      logic dual;
      logic run;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_evt_qual.sv
module tmr_evt_qual
   import tmr_pkg::*;
#(
   parameter int SVC_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  ctl_t ctl,
   input  logic ctl_wr,
   input  logic ext_s,
   input  logic gate_s,
   input  logic pre_tick,
   output logic svc,
   output logic adv
);
   if (SVC_DIV < 1 || (SVC_DIV & (SVC_DIV - 1)) != 0) begin : g_bad_div
      $error("tmr_evt_qual: SVC_DIV must be a power of two");
   end

   // service slot generation
   if (SVC_DIV == 1) begin : g_every
      assign svc = 1'b1;
   end else begin : g_phase
      localparam int PH_W = $clog2(SVC_DIV);
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase <= '0;
         else        phase <= phase + 1'b1;
      end
      assign svc = (phase == PH_W'(SVC_DIV - 1));
   end

   // edge detect on the synchronised external clock
   logic ext_d;
   logic rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_d <= 1'b0;
      else        ext_d <= ext_s;
   end
   assign rise = ext_s & ~ext_d;

   logic evt_now;
   logic latchable;
   always_comb begin
      case (ctl.src)
         SRC_CLK: evt_now = 1'b1;
         SRC_EXT: evt_now = rise;
         SRC_PRE: evt_now = pre_tick;
         default: evt_now = 1'b0;
      endcase
   end
   assign latchable = (ctl.src != SRC_CLK);

   // hold an edge or pulse until the next service slot
   logic pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend <= 1'b0;
      else if (ctl_wr || !ctl.run || svc) pend <= 1'b0;
      else if (latchable && evt_now)    pend <= 1'b1;
   end

   logic gate_ok;
   assign gate_ok = !ctl.gate_en || gate_s;
   assign adv     = svc && ctl.run && gate_ok && (evt_now || pend);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         dual,
   input  logic         sel_clr,
   input  logic         cnt_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] lim_pri,
   input  logic [W-1:0] lim_sec,
   output logic [W-1:0] count,
   output logic         sel,
   output logic         tc,
   output logic         out_q,
   output logic         done
);
   localparam logic [W:0] FULL = {1'b1, {W{1'b0}}};

   logic [W:0]   nxt;
   logic [W-1:0] lim_act;
   logic [W:0]   lim_eff;
   logic         hit;
   logic         sel_nxt;

   assign nxt     = {1'b0, count} + 1'b1;
   assign lim_act = sel ? lim_sec : lim_pri;
   assign lim_eff = (lim_act == '0) ? FULL : {1'b0, lim_act};
   assign hit     = adv && !cnt_we && (nxt == lim_eff);
   assign done    = hit && (!dual || sel);

   always_comb begin
      if (sel_clr || !dual) sel_nxt = 1'b0;
      else if (hit)         sel_nxt = ~sel;
      else                  sel_nxt = sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         sel   <= 1'b0;
         tc    <= 1'b0;
         out_q <= 1'b1;
      end else begin
         if (cnt_we)   count <= wdata;
         else if (hit) count <= '0;
         else if (adv) count <= nxt[W-1:0];
         sel   <= sel_nxt;
         tc    <= hit;
         out_q <= dual ? ~sel_nxt : ~hit;
      end
   end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import tmr_pkg::*;
#(
   parameter int W           = 16,
   parameter int SVC_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_we,
   input  logic         pri_we,
   input  logic         sec_we,
   input  logic         ctl_we,
   input  logic [W-1:0] wdata,
   input  logic         ext_clk,
   input  logic         ext_gate,
   input  logic         pre_tick,
   output logic [W-1:0] count_q,
   output logic         tmr_out,
   output logic         tc_irq
);
   if (W < CTL_W) begin : g_bad_w
      $error("evt_timer: W must hold the control word");
   end

   ctl_t         ctl_q;
   logic [W-1:0] pri_q;
   logic [W-1:0] sec_q;
   logic         ext_s;
   logic         gate_s;
   logic         svc_w;
   logic         adv_w;
   logic         sel_w;
   logic         done_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         pri_q <= '0;
         sec_q <= '0;
      end else begin
         if (ctl_we)                       ctl_q     <= ctl_t'(wdata[CTL_W-1:0]);
         else if (done_w && !ctl_q.cont)   ctl_q.run <= 1'b0;
         if (pri_we) pri_q <= wdata;
         if (sec_we) sec_q <= wdata;
      end
   end

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s)
   );
   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .d(ext_gate), .q(gate_s)
   );

   tmr_evt_qual #(.SVC_DIV(SVC_DIV)) u_qual (
      .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .ctl_wr(ctl_we),
      .ext_s(ext_s), .gate_s(gate_s), .pre_tick(pre_tick),
      .svc(svc_w), .adv(adv_w)
   );

   tmr_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .adv(adv_w), .dual(ctl_q.dual),
      .sel_clr(ctl_we), .cnt_we(cnt_we), .wdata(wdata),
      .lim_pri(pri_q), .lim_sec(sec_q),
      .count(count_q), .sel(sel_w), .tc(tc_irq), .out_q(tmr_out),
      .done(done_w)
   );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cnt_we,
   input logic         ctl_we,
   input logic [W-1:0] wdata,
   input logic [W-1:0] count_q,
   input logic         tmr_out,
   input logic         tc_irq,
   input logic         dual,
   input logic         svc,
   input logic         sel,
   input logic [W-1:0] pri,
   input logic [W-1:0] sec
);
   // R2: a self-driven count change never lands on a non-zero active limit
   assert_never_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_we) && !$past(ctl_we) && count_q != $past(count_q)
       && ($past(sel) ? $past(sec) : $past(pri)) != '0)
      |-> count_q != ($past(sel) ? $past(sec) : $past(pri)));

   // R2: the count reads zero while the terminal-count pulse is high
   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq |-> count_q == '0);

   // R5: the count moves on its own only in a service slot
   assert_service_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_we) && count_q != $past(count_q)) |-> $past(svc));

   // R9: a count write is loaded exactly
   assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt_we) |-> count_q == $past(wdata));

   // R3: in single-limit mode a Low output comes only with the pulse
   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dual && !$past(dual) && !tmr_out) |-> tc_irq);

   // R4: in dual-limit mode the level changes only at a wrap
   assert_dual_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dual && $past(dual) && !$past(ctl_we) && tmr_out != $past(tmr_out)) |-> tc_irq);
endmodule

bind evt_timer evt_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .ctl_we(ctl_we), .wdata(wdata),
   .count_q(count_q), .tmr_out(tmr_out), .tc_irq(tc_irq),
   .dual(ctl_q.dual), .svc(svc_w), .sel(sel_w), .pri(pri_q), .sec(sec_q)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_we = 1'b0, pri_we = 1'b0, sec_we = 1'b0, ctl_we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic ext_clk = 1'b0, ext_gate = 1'b0, pre_tick = 1'b0;
   logic [W-1:0] count_q;
   logic tmr_out, tc_irq;

   always #2.5 clk = ~clk;

   evt_timer #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .pri_we(pri_we),
      .sec_we(sec_we), .ctl_we(ctl_we), .wdata(wdata), .ext_clk(ext_clk),
      .ext_gate(ext_gate), .pre_tick(pre_tick), .count_q(count_q),
      .tmr_out(tmr_out), .tc_irq(tc_irq)
   );

   // scoreboard: sel 0 count, 1 output pin, 2 pulse, 3 count non-zero, 9 fixed value
   typedef struct {
      string req;
      int    sel;
      int    act;
      int    exp;
   } item_t;

   item_t sbq[$];
   event  chk_ev;
   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int observe(item_t it);
      case (it.sel)
         0: return int'(count_q);
         1: return int'(tmr_out);
         2: return int'(tc_irq);
         3: return int'(count_q != '0);
         default: return it.act;
      endcase
   endfunction

   task automatic drain();
      while (sbq.size() > 0) begin
         item_t it = sbq.pop_front();
         int a = observe(it);
         n_chk++;
         if (a != it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", it.req, a, it.exp);
         end
      end
   endtask

   initial forever begin
      @(chk_ev);
      drain();
   end

   task automatic expect_sig(string r, int s, int e);
      item_t it;
      it.req = r; it.sel = s; it.act = 0; it.exp = e;
      sbq.push_back(it);
      -> chk_ev;
      #0;
   endtask

   task automatic expect_val(string r, int a, int e);
      item_t it;
      it.req = r; it.sel = 9; it.act = a; it.exp = e;
      sbq.push_back(it);
      -> chk_ev;
      #0;
   endtask

   // k: 0 count, 1 primary, 2 secondary, 3 control
   task automatic wr(int k, int d);
      @(negedge clk);
      wdata = W'(d);
      case (k)
         0: cnt_we = 1'b1;
         1: pri_we = 1'b1;
         2: sec_we = 1'b1;
         default: ctl_we = 1'b1;
      endcase
      @(negedge clk);
      cnt_we = 1'b0; pri_we = 1'b0; sec_we = 1'b0; ctl_we = 1'b0;
   endtask

   task automatic wait_tc(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tc_irq && n < 500);
   endtask

   task automatic finish_run();
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
   end

   initial begin
      int n, tcs, lows, v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, stopped
      expect_sig("R1 count", 0, 0);
      expect_sig("R1 out", 1, 1);
      expect_sig("R1 tc", 2, 0);
      repeat (20) @(negedge clk);
      expect_sig("R1 stopped", 0, 0);

      // R2/R3/R5 single mode, internal source, limit 5
      wr(1, 5);
      wr(3, 32'h05);
      wait_tc(n);
      expect_sig("R2 wrap count", 0, 0);
      expect_sig("R2 tc", 2, 1);
      expect_sig("R3 out low", 1, 0);
      @(negedge clk);
      expect_sig("R2 tc one clock", 2, 0);
      expect_sig("R3 out high", 1, 1);
      repeat (3) @(negedge clk);
      expect_sig("R2 one step", 0, 1);
      wait_tc(n);
      wait_tc(n);
      expect_val("R5 period", n, 20);

      // R9 write wins over a due increment
      repeat (3) @(negedge clk);
      cnt_we = 1'b1; wdata = 16'd2;
      @(negedge clk);
      cnt_we = 1'b0;
      expect_sig("R9 write priority", 0, 2);
      repeat (4) @(negedge clk);
      expect_sig("R9 resumes", 0, 3);

      // R12 watchdog kept alive
      tcs = 0;
      wr(0, 0);
      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (tc_irq) tcs++;
         end
         wr(0, 0);
         if (tc_irq) tcs++;
      end
      expect_val("R12 no pulse", tcs, 0);

      // R11 non-continuous single mode
      wr(3, 32'h01);
      wr(0, 0);
      wait_tc(n);
      expect_sig("R11 wrap", 0, 0);
      tcs = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (tc_irq) tcs++;
      end
      expect_val("R11 no more pulses", tcs, 0);
      expect_sig("R11 held zero", 0, 0);

      // R4 dual mode, primary 3, secondary 2
      wr(1, 3);
      wr(2, 2);
      wr(3, 32'h07);
      wr(0, 0);
      wait_tc(n);
      if (tmr_out) wait_tc(n);
      expect_sig("R4 secondary low", 1, 0);
      lows = 0; n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!tmr_out) lows++;
      end while (!tc_irq && n < 100);
      expect_val("R4 low span", n, 8);
      expect_val("R4 low samples", lows, 7);
      expect_sig("R4 primary high", 1, 1);
      wait_tc(n);
      expect_val("R4 high span", n, 12);
      expect_sig("R4 back low", 1, 0);

      // R10 limit zero is full range
      wr(3, 32'h05);
      wr(1, 0);
      wr(0, 32'hFFFE);
      repeat (4) @(negedge clk);
      expect_sig("R10 reaches FFFF", 0, 32'hFFFF);
      wait_tc(n);
      expect_val("R10 wrap soon", int'(n <= 4), 1);
      expect_sig("R10 wrap to zero", 0, 0);

      // R7 prescaler source
      wr(1, 100);
      wr(3, 32'h15);
      wr(0, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         pre_tick = 1'b1;
         @(negedge clk);
         pre_tick = 1'b0;
         repeat (6) @(negedge clk);
      end
      expect_sig("R7 three pulses", 0, 3);
      repeat (20) @(negedge clk);
      expect_sig("R7 idle", 0, 3);

      // R6 external source
      wr(3, 32'h0D);
      wr(0, 0);
      ext_clk = 1'b1;
      repeat (6) @(negedge clk);
      expect_sig("R6 first edge", 0, 1);
      repeat (20) @(negedge clk);
      expect_sig("R6 level ignored", 0, 1);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
      ext_clk = 1'b1;
      repeat (6) @(negedge clk);
      expect_sig("R6 second edge", 0, 2);
      ext_clk = 1'b0;

      // R8 gate
      wr(3, 32'h25);
      wr(0, 0);
      repeat (40) @(negedge clk);
      expect_sig("R8 gate low holds", 0, 0);
      ext_gate = 1'b1;
      repeat (8) @(negedge clk);
      expect_sig("R8 gate high counts", 3, 1);
      ext_gate = 1'b0;
      repeat (8) @(negedge clk);
      v = int'(count_q);
      repeat (40) @(negedge clk);
      expect_sig("R8 gate low again", 0, v);

      finish_run();
   end
endmodule